// File: doc/BRIEF.md
# SIMT Warp Round-Robin Scheduler

This block keeps the execution context of every warp of one streaming multiprocessor and hands one warp at a time to the downstream pipeline. A context is a program counter, a 32-bit active-thread mask and a lifecycle state (Ready, Active, Waiting, Finished). Program counter and mask live in a small synchronous RAM indexed by warp number. The state codes sit in flops beside it because the picker must see every state in the same cycle. Contexts are written while the block is idle. A start pulse then begins a launch.

Only Ready warps are eligible, and they are picked in round-robin order. A picked warp becomes Active and is sent out as a run of rows, each row as wide as the lane count. When the pipeline is done with the warp it reports back. The report carries a new program counter and mask, plus a kind: go on, wait at a barrier, or exit. The barrier releases once every warp that has not exited is waiting. When all warps have exited, the block raises a one-cycle done pulse and returns to idle. A downstream stall freezes the row being offered.

Top module: `warp_rr_sched`

## Requirements
- R1: After reset no row is offered, done is low, and every warp is treated as Finished until it is loaded.
- R2: A picked warp is offered as ROWS = THREADS/LANES consecutive rows numbered 0 to ROWS-1. Row r carries mask bits [r*LANES +: LANES] and the warp's program counter.
- R3: Row 0 of the first warp is offered in the second cycle after start is sampled. When another warp is Ready, its row 0 follows the previous warp's last row in the very next cycle.
- R4: Each new pick is the first Ready warp at or after the round-robin pointer, with wrap-around. The pointer moves to the warp after the one picked, and start resets it to warp 0.
- R5: While stall_i is high, the offered row holds all of its fields unchanged and does not advance.
- R6: An update of kind 0 (continue) stores the new program counter and mask and makes the warp Ready. Its next issue carries the new values.
- R7: An update of kind 1 (barrier) makes the warp Waiting. No Waiting warp is issued until every warp that has not exited is Waiting, and then all of them become Ready together.
- R8: An update of kind 2 (exit) makes the warp Finished, and it is not issued again in that launch.
- R9: When every warp is Finished, done_o is high for exactly one cycle. After that no row is offered until the next start.
- R10: A warp whose context was not loaded before start is never issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a launch (sampled only while idle) |
| init_we_i | input | 1 | Load a warp context (sampled only while idle) |
| init_warp_i | input | WW | Warp number to load |
| init_pc_i | input | PC_W | Initial program counter |
| init_mask_i | input | THREADS | Initial active-thread mask |
| upd_valid_i | input | 1 | Pipeline reports back on a warp |
| upd_warp_i | input | WW | Warp being reported |
| upd_kind_i | input | 2 | 0 continue, 1 barrier, 2 exit, 3 treated as continue |
| upd_pc_i | input | PC_W | New program counter |
| upd_mask_i | input | THREADS | New active-thread mask |
| stall_i | input | 1 | Downstream cannot take a row |
| iss_valid_o | output | 1 | A row is offered |
| iss_warp_o | output | WW | Warp of the offered row |
| iss_row_o | output | RW | Row index within the warp |
| iss_pc_o | output | PC_W | Program counter of the warp |
| iss_mask_o | output | LANES | Thread-mask slice for this row |
| done_o | output | 1 | One-cycle pulse when all warps have exited |

## Verification
A launch with all eight warps loaded and no stall shows back-to-back issue and the exact pick order. A continue report sent for a low-numbered warp mid-sweep separates true round-robin from lowest-index priority, because a priority picker would take it early. A full set of barrier reports, released by the last arrival, shows the pointer wrapping around. Launches with random subsets of loaded warps, random stalls and a random mix of continue, barrier and exit reports check against a bench model that tracks each warp's state. Unloaded, waiting or finished warps must never appear, stalled rows must freeze, and each launch must end in exactly one done pulse.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;

    typedef enum logic [1:0] {
        WS_READY    = 2'd0,
        WS_ACTIVE   = 2'd1,
        WS_WAITING  = 2'd2,
        WS_FINISHED = 2'd3
    } warp_state_e;

    typedef enum logic [1:0] {
        UPD_CONTINUE = 2'd0,
        UPD_BARRIER  = 2'd1,
        UPD_EXIT     = 2'd2
    } upd_kind_e;

    // Next index with wrap-around over n entries.
    function automatic int unsigned wrap_inc(input int unsigned idx, input int unsigned n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

    // State a warp takes on a pipeline report; code 3 acts as continue.
    function automatic warp_state_e kind_to_state(input logic [1:0] kind);
        case (kind)
            UPD_BARRIER: return WS_WAITING;
            UPD_EXIT:    return WS_FINISHED;
            default:     return WS_READY;
        endcase
    endfunction

endpackage

// File: rtl/wsched_ctx_ram.sv
module wsched_ctx_ram #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 64,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic             re,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/wsched_rr_pick.sv
module wsched_rr_pick #(
    parameter int N = 8,
    localparam int AW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [AW-1:0] ptr,
    output logic          gnt_valid,
    output logic [AW-1:0] gnt_idx
);
    // Walk offsets from far to near so the nearest request is written last.
    always_comb begin
        gnt_valid = 1'b0;
        gnt_idx   = '0;
        for (int k = N - 1; k >= 0; k--) begin
            int unsigned cand;
            cand = (32'(ptr) + 32'(k)) % 32'(N);
            if (req[cand]) begin
                gnt_valid = 1'b1;
                gnt_idx   = AW'(cand);
            end
        end
    end
endmodule

// File: rtl/wsched_row_seq.sv
module wsched_row_seq #(
    parameter int NUM_WARPS = 8,
    parameter int ROWS = 4,
    localparam int WW = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [WW-1:0] load_warp,
    input  logic          stall,
    output logic          valid,
    output logic [WW-1:0] warp,
    output logic [RW-1:0] row,
    output logic          free
);
    logic last_row;
    logic advance;

    assign last_row = (row == RW'(ROWS - 1));
    assign advance  = valid && !stall;
    assign free     = !valid || (advance && last_row);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            warp  <= '0;
            row   <= '0;
        end else if (load) begin
            valid <= 1'b1;
            warp  <= load_warp;
            row   <= '0;
        end else if (advance) begin
            if (last_row) valid <= 1'b0;
            else          row   <= row + RW'(1);
        end
    end
endmodule

// File: rtl/warp_rr_sched.sv
module warp_rr_sched
    import warp_sched_pkg::*;
#(
    parameter int NUM_WARPS = 8,
    parameter int LANES = 8,
    parameter int THREADS = 32,
    parameter int PC_W = 32,
    localparam int WW = (NUM_WARPS > 1) ? $clog2(NUM_WARPS) : 1,
    localparam int ROWS = THREADS / LANES,
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic               init_we_i,
    input  logic [WW-1:0]      init_warp_i,
    input  logic [PC_W-1:0]    init_pc_i,
    input  logic [THREADS-1:0] init_mask_i,
    input  logic               upd_valid_i,
    input  logic [WW-1:0]      upd_warp_i,
    input  logic [1:0]         upd_kind_i,
    input  logic [PC_W-1:0]    upd_pc_i,
    input  logic [THREADS-1:0] upd_mask_i,
    input  logic               stall_i,
    output logic               iss_valid_o,
    output logic [WW-1:0]      iss_warp_o,
    output logic [RW-1:0]      iss_row_o,
    output logic [PC_W-1:0]    iss_pc_o,
    output logic [LANES-1:0]   iss_mask_o,
    output logic               done_o
);
    typedef struct packed {
        logic [PC_W-1:0]    pc;
        logic [THREADS-1:0] mask;
    } ctx_t;

    warp_state_e          st_q [NUM_WARPS];
    logic                 running_q;
    logic                 done_q;
    logic [WW-1:0]        rr_ptr_q;
    logic [NUM_WARPS-1:0] ready_vec, busy_vec, wait_vec, fin_vec;
    logic                 all_fin, release_bar, sel_fire, pick_valid, seq_free;
    logic [WW-1:0]        pick_idx;
    warp_state_e          upd_state;
    logic                 ram_we;
    logic [WW-1:0]        ram_waddr;
    ctx_t                 wr_ctx, rd_ctx;

    // Per-warp state decode
    for (genvar g = 0; g < NUM_WARPS; g++) begin : g_state_vec
        assign ready_vec[g] = (st_q[g] == WS_READY);
        assign busy_vec[g]  = (st_q[g] == WS_READY) || (st_q[g] == WS_ACTIVE);
        assign wait_vec[g]  = (st_q[g] == WS_WAITING);
        assign fin_vec[g]   = (st_q[g] == WS_FINISHED);
    end

    assign all_fin     = &fin_vec;
    assign release_bar = running_q && (|wait_vec) && !(|busy_vec);
    assign sel_fire    = running_q && seq_free && pick_valid;
    assign upd_state   = kind_to_state(upd_kind_i);

    wsched_rr_pick #(.N(NUM_WARPS)) u_pick (
        .req       (ready_vec),
        .ptr       (rr_ptr_q),
        .gnt_valid (pick_valid),
        .gnt_idx   (pick_idx)
    );

    // Lifecycle state per warp
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < NUM_WARPS; w++) st_q[w] <= WS_FINISHED;
        end else begin
            for (int w = 0; w < NUM_WARPS; w++) begin
                if (!running_q && init_we_i && init_warp_i == WW'(w))
                    st_q[w] <= WS_READY;
                else if (running_q && upd_valid_i && upd_warp_i == WW'(w))
                    st_q[w] <= upd_state;
                else if (release_bar && st_q[w] == WS_WAITING)
                    st_q[w] <= WS_READY;
                else if (sel_fire && pick_idx == WW'(w))
                    st_q[w] <= WS_ACTIVE;
            end
        end
    end

    // Launch control and round-robin pointer
    always_ff @(posedge clk) begin
        if (rst) begin
            running_q <= 1'b0;
            done_q    <= 1'b0;
            rr_ptr_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (!running_q) begin
                if (start_i) begin
                    running_q <= 1'b1;
                    rr_ptr_q  <= '0;
                end
            end else if (all_fin) begin
                running_q <= 1'b0;
                done_q    <= 1'b1;
            end else if (sel_fire) begin
                rr_ptr_q <= WW'(wrap_inc(32'(pick_idx), NUM_WARPS));
            end
        end
    end

    // Context RAM: loads while idle, pipeline reports while running
    assign ram_we    = running_q ? upd_valid_i : init_we_i;
    assign ram_waddr = running_q ? upd_warp_i : init_warp_i;
    assign wr_ctx    = running_q ? ctx_t'{pc: upd_pc_i, mask: upd_mask_i}
                                 : ctx_t'{pc: init_pc_i, mask: init_mask_i};

    wsched_ctx_ram #(.DEPTH(NUM_WARPS), .WIDTH($bits(ctx_t))) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (wr_ctx),
        .re    (sel_fire),
        .raddr (pick_idx),
        .rdata (rd_ctx)
    );

    wsched_row_seq #(.NUM_WARPS(NUM_WARPS), .ROWS(ROWS)) u_rows (
        .clk       (clk),
        .rst       (rst),
        .load      (sel_fire),
        .load_warp (pick_idx),
        .stall     (stall_i),
        .valid     (iss_valid_o),
        .warp      (iss_warp_o),
        .row       (iss_row_o),
        .free      (seq_free)
    );

    // Lane slice of the thread mask for the current row
    always_comb begin
        iss_mask_o = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (iss_row_o == RW'(r)) iss_mask_o = rd_ctx.mask[r*LANES +: LANES];
        end
    end

    assign iss_pc_o = rd_ctx.pc;
    assign done_o   = done_q;

endmodule

// File: rtl/warp_rr_sched_chk.sv
module warp_rr_sched_chk #(
    parameter int WW = 3,
    parameter int RW = 2,
    parameter int ROWS = 4,
    parameter int PC_W = 32,
    parameter int LANES = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             stall_i,
    input logic             iss_valid_o,
    input logic [WW-1:0]    iss_warp_o,
    input logic [RW-1:0]    iss_row_o,
    input logic [PC_W-1:0]  iss_pc_o,
    input logic [LANES-1:0] iss_mask_o,
    input logic             done_o,
    input logic             all_fin
);
    // R2: a warp always begins at row 0
    a_r2_first_row: assert property (@(posedge clk) disable iff (rst)
        $rose(iss_valid_o) |-> (iss_row_o == '0));

    // R2: an accepted row that is not the last is followed by the next row of the same warp
    a_r2_row_step: assert property (@(posedge clk) disable iff (rst)
        (iss_valid_o && !stall_i && iss_row_o != RW'(ROWS - 1)) |=>
        (iss_valid_o && iss_row_o == $past(iss_row_o) + RW'(1) && iss_warp_o == $past(iss_warp_o)));

    // R5: a stalled row is held unchanged
    a_r5_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (iss_valid_o && stall_i) |=>
        (iss_valid_o && $stable(iss_warp_o) && $stable(iss_row_o) &&
         $stable(iss_pc_o) && $stable(iss_mask_o)));

    // R9: done lasts one cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9: done only after every warp had finished, and nothing is offered with it
    a_r9_done_all_fin: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($past(all_fin) && !iss_valid_o));

    // R9: nothing is offered in the cycle after done
    a_r9_done_quiet: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !iss_valid_o);
endmodule

bind warp_rr_sched warp_rr_sched_chk #(
    .WW(WW), .RW(RW), .ROWS(ROWS), .PC_W(PC_W), .LANES(LANES)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .stall_i     (stall_i),
    .iss_valid_o (iss_valid_o),
    .iss_warp_o  (iss_warp_o),
    .iss_row_o   (iss_row_o),
    .iss_pc_o    (iss_pc_o),
    .iss_mask_o  (iss_mask_o),
    .done_o      (done_o),
    .all_fin     (all_fin)
);

// File: tb/tb_warp_rr_sched.sv
module tb_warp_rr_sched;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 8;
    localparam int L = 8;
    localparam int TH = 32;
    localparam int PCW = 32;
    localparam int ROWS = TH / L;
    localparam int WW = 3;
    localparam int RW = 2;
    localparam int LOG_MAX = 8192;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic init_we_i = 1'b0;
    logic [WW-1:0] init_warp_i = '0;
    logic [PCW-1:0] init_pc_i = '0;
    logic [TH-1:0] init_mask_i = '0;
    logic upd_valid_i = 1'b0;
    logic [WW-1:0] upd_warp_i = '0;
    logic [1:0] upd_kind_i = '0;
    logic [PCW-1:0] upd_pc_i = '0;
    logic [TH-1:0] upd_mask_i = '0;
    logic stall = 1'b0;
    logic iss_valid;
    logic [WW-1:0] iss_warp;
    logic [RW-1:0] iss_row;
    logic [PCW-1:0] iss_pc;
    logic [L-1:0] iss_mask;
    logic done_o;

    always #(CLK_PERIOD / 2) clk = ~clk;

    warp_rr_sched #(.NUM_WARPS(NW), .LANES(L), .THREADS(TH), .PC_W(PCW)) dut (
        .clk(clk), .rst(rst), .start_i(start_i),
        .init_we_i(init_we_i), .init_warp_i(init_warp_i), .init_pc_i(init_pc_i), .init_mask_i(init_mask_i),
        .upd_valid_i(upd_valid_i), .upd_warp_i(upd_warp_i), .upd_kind_i(upd_kind_i),
        .upd_pc_i(upd_pc_i), .upd_mask_i(upd_mask_i), .stall_i(stall),
        .iss_valid_o(iss_valid), .iss_warp_o(iss_warp), .iss_row_o(iss_row),
        .iss_pc_o(iss_pc), .iss_mask_o(iss_mask), .done_o(done_o)
    );

    // Bench model: 0 ready, 1 active, 2 waiting, 3 finished
    int n_chk = 0;
    int n_bad = 0;
    int stat [NW];
    logic [PCW-1:0] exp_pc [NW];
    logic [TH-1:0] exp_mask [NW];
    int order_log [LOG_MAX];
    int n_log = 0;
    int pend [$];
    int done_cnt = 0;
    bit prev_valid = 1'b0;
    int prev_warp = 0;
    int prev_row = 0;
    logic [PCW-1:0] prev_pc = '0;
    logic [L-1:0] prev_mask = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic monitor();
        bit cont;
        int w;
        cont = prev_valid && (stall || prev_row != ROWS - 1);
        if (prev_valid && stall)
            check(iss_valid && iss_warp == WW'(prev_warp) && iss_row == RW'(prev_row) &&
                  iss_pc == prev_pc && iss_mask == prev_mask, "R5", "stalled row changed",
                  {iss_warp, iss_row}, {WW'(prev_warp), RW'(prev_row)});
        else if (prev_valid && prev_row != ROWS - 1)
            check(iss_valid && iss_warp == WW'(prev_warp) && iss_row == RW'(prev_row + 1),
                  "R2", "row step", {iss_valid, iss_warp, iss_row},
                  {1'b1, WW'(prev_warp), RW'(prev_row + 1)});
        if (prev_valid && !stall && prev_row == ROWS - 1) pend.push_back(prev_warp);
        if (iss_valid) begin
            w = int'(iss_warp);
            check(iss_pc == exp_pc[w], "R6", "row pc", iss_pc, exp_pc[w]);
            check(iss_mask == exp_mask[w][int'(iss_row)*L +: L], "R2", "row mask slice",
                  iss_mask, exp_mask[w][int'(iss_row)*L +: L]);
            if (!cont) begin
                check(iss_row == '0, "R2", "new warp starts at row 0", iss_row, 0);
                check(stat[w] == 0, "R7", "issued warp was not ready (R8/R10)", stat[w], 0);
                stat[w] = 1;
                if (n_log < LOG_MAX) begin
                    order_log[n_log] = w;
                    n_log++;
                end
            end
        end
        if (done_o) begin
            done_cnt++;
            for (int k = 0; k < NW; k++)
                check(stat[k] == 3, "R9", "done with unfinished warp", stat[k], 3);
            check(!iss_valid, "R9", "row offered with done", iss_valid, 0);
        end
        prev_valid = iss_valid;
        prev_warp = int'(iss_warp);
        prev_row = int'(iss_row);
        prev_pc = iss_pc;
        prev_mask = iss_mask;
    endtask

    task automatic tick();
        @(negedge clk);
        monitor();
    endtask

    task automatic load_ctx(input int w, input logic [PCW-1:0] pc, input logic [TH-1:0] m);
        init_we_i = 1'b1;
        init_warp_i = WW'(w);
        init_pc_i = pc;
        init_mask_i = m;
        stat[w] = 0;
        exp_pc[w] = pc;
        exp_mask[w] = m;
        tick();
        init_we_i = 1'b0;
    endtask

    task automatic send_upd(input int w, input int kind, input logic [PCW-1:0] pc,
                            input logic [TH-1:0] m);
        bit busy;
        bit anyw;
        upd_valid_i = 1'b1;
        upd_warp_i = WW'(w);
        upd_kind_i = 2'(kind);
        upd_pc_i = pc;
        upd_mask_i = m;
        exp_pc[w] = pc;
        exp_mask[w] = m;
        stat[w] = (kind == 1) ? 2 : (kind == 2) ? 3 : 0;
        busy = 1'b0;
        anyw = 1'b0;
        for (int k = 0; k < NW; k++) begin
            if (stat[k] == 0 || stat[k] == 1) busy = 1'b1;
            if (stat[k] == 2) anyw = 1'b1;
        end
        if (anyw && !busy)
            for (int k = 0; k < NW; k++) if (stat[k] == 2) stat[k] = 0;
        tick();
        upd_valid_i = 1'b0;
    endtask

    task automatic pend_remove(input int w);
        for (int i = 0; i < pend.size(); i++) begin
            if (pend[i] == w) begin
                pend.delete(i);
                break;
            end
        end
    endtask

    task automatic do_start();
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
        summary();
        $finish;
    end

    initial begin
        int seed_dummy;
        int n_valid;
        int base;
        int d0;
        int w;
        int r;
        int exp_ord [9];
        seed_dummy = $urandom(32'd20240611);
        for (int k = 0; k < NW; k++) begin
            stat[k] = 3;
            exp_pc[k] = '0;
            exp_mask[k] = '0;
        end

        // Reset state (R1)
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tick();
        check(!iss_valid && !done_o, "R1", "idle after reset", {iss_valid, done_o}, 0);
        repeat (3) tick();
        check(!iss_valid, "R1", "no issue without start", iss_valid, 0);

        // Start with nothing loaded: immediate done, no issue (R9, R10)
        do_start();
        check(!done_o, "R9", "done too early", done_o, 0);
        tick();
        check(done_o, "R9", "done with no warps loaded", done_o, 1);
        tick();
        check(!done_o && !iss_valid, "R10", "quiet after empty launch", {done_o, iss_valid}, 0);

        // Full launch: latency, back-to-back, round-robin order (R3, R4)
        for (int k = 0; k < NW; k++) load_ctx(k, PCW'(32'h100 + k * 16), $urandom);
        do_start();
        check(!iss_valid, "R3", "row too early", iss_valid, 0);
        tick();
        check(iss_valid && iss_warp == 0 && iss_row == 0, "R3", "first row latency",
              {iss_valid, iss_warp, iss_row}, {1'b1, 3'd0, 2'd0});
        n_valid = 1;
        for (int c = 1; c <= 45; c++) begin
            if (c == 13) begin
                pend_remove(1);
                send_upd(1, 0, 32'h0000_0A00, $urandom);
            end else begin
                tick();
            end
            if (iss_valid) n_valid++;
        end
        check(n_valid == 36, "R3", "back-to-back rows", n_valid, 36);
        exp_ord = '{0, 1, 2, 3, 4, 5, 6, 7, 1};
        for (int i = 0; i < 9; i++)
            check(order_log[i] == exp_ord[i], "R4", "round-robin order", order_log[i], exp_ord[i]);

        // Stall holds the row (R5)
        pend_remove(5);
        send_upd(5, 0, 32'h0000_0B40, $urandom);
        tick();
        check(iss_valid && iss_warp == 5 && iss_row == 0, "R6", "continued warp issued",
              {iss_warp, iss_row}, {3'd5, 2'd0});
        stall = 1'b1;
        repeat (6) tick();
        check(iss_valid && iss_row == 0, "R5", "row frozen under stall", iss_row, 0);
        stall = 1'b0;
        repeat (8) tick();
        check(!iss_valid, "R5", "warp drained after stall", iss_valid, 0);

        // Barrier: held until the last arrival, then reissued with wrap (R7, R4)
        check(pend.size() == NW, "R7", "all warps reported back", pend.size(), NW);
        base = n_log;
        for (int i = 0; i < NW - 1; i++) begin
            w = pend.pop_front();
            send_upd(w, 1, PCW'(32'h2000 + w * 8), $urandom);
            tick();
            check(!iss_valid, "R7", "waiting warp issued early", iss_valid, 0);
        end
        w = pend.pop_front();
        send_upd(w, 1, PCW'(32'h2000 + w * 8), $urandom);
        repeat (40) tick();
        exp_ord[0:7] = '{6, 7, 0, 1, 2, 3, 4, 5};
        for (int i = 0; i < NW; i++)
            check(order_log[base + i] == exp_ord[i], "R7", "release order (R4 wrap)",
                  order_log[base + i], exp_ord[i]);

        // Exit all: single done pulse, no further issue (R8, R9)
        check(pend.size() == NW, "R8", "all warps back before exit", pend.size(), NW);
        d0 = done_cnt;
        base = n_log;
        for (int i = 0; i < NW; i++) begin
            w = pend.pop_front();
            send_upd(w, 2, '0, '0);
        end
        repeat (3) tick();
        check(done_cnt == d0 + 1, "R9", "one done pulse", done_cnt, d0 + 1);
        repeat (5) tick();
        check(n_log == base && !iss_valid, "R8", "finished warp issued", n_log, base);

        // Random launches (R2, R5, R6, R7, R8, R10)
        for (int launch = 0; launch < 4; launch++) begin
            d0 = done_cnt;
            check(pend.size() == 0, "R9", "pipeline empty before launch", pend.size(), 0);
            r = $urandom % NW;
            for (int k = 0; k < NW; k++)
                if (k == r || ($urandom % 2) == 1) load_ctx(k, $urandom, $urandom);
            do_start();
            for (int c = 0; c < 20000 && done_cnt == d0; c++) begin
                stall = (($urandom % 4) == 0);
                if (pend.size() > 0 && ($urandom % 3) == 0) begin
                    w = pend.pop_front();
                    r = $urandom % 100;
                    send_upd(w, (r < 60) ? 0 : (r < 80) ? 1 : 2, $urandom, $urandom);
                end else begin
                    tick();
                end
            end
            stall = 1'b0;
            check(done_cnt == d0 + 1, "R9", "random launch completed", done_cnt, d0 + 1);
            repeat (4) tick();
            check(!iss_valid, "R9", "idle after random launch", iss_valid, 0);
        end

        summary();
        $finish;
    end
endmodule